// File: doc/BRIEF.md
# Reset-Loaded Configuration Register Bank

This block holds the configuration of a nonvolatile memory controller. While reset is held it copies a two-byte shadow word, presented on parallel input ports, into a 10-bit prescaler divider and four upper configuration bits. The other fields take constant reset values. After reset the CPU reads and writes the registers through a byte-wide bus with a write strobe, an address and write data. Read data is combinational.

Each field applies its own write policy. The policy depends on the operating mode (normal or special), on the latch-enable and program-enable flags from the programming controller, and on the bank's own protect-lock bit. Some fields are free, some can be written only in special mode, some accept one write in normal mode, and one field only accepts a single clearing write in normal mode. The current field values drive output ports that the rest of the controller uses.

Address map: 0 holds the divider upper bits in bits 1:0. 1 holds divider bits 7:0. 2 is the configuration register: bit7 debug-lockout disable, bit6 shadow disable, bit5 reserved (shadow-loaded, read-only), bit4 flash open, bit3 fixed 1, bit2 wait-mode stop, bit1 protect lock, bit0 dummy. 3 is the protect register: bit7 shadow protect, bit6 fixed 1, bits 5:0 block protect. Reset is synchronous and active low.

Top module: `cfg_bank`

## Requirements
- R1: During reset the divider loads {shadow_hi_i[1:0], shadow_lo_i}. The first read after reset returns these on addresses 0 and 1.
- R2: During reset, configuration bits 7:4 load shadow_hi_i[7:4]. Wait-stop resets to 1, protect lock and dummy reset to 0, and the protect register resets to all ones.
- R3: While latch_en_i is 1, writes to either divider byte are ignored in both modes. A write blocked this way does not use up the one-time write.
- R4: In normal mode each divider byte accepts only its first write after reset, and a write to one byte does not use up the other byte's write. In special mode the divider bytes accept any number of writes.
- R5: The debug-lockout-disable and shadow-disable bits change only on writes in special mode. In normal mode they ignore writes.
- R6: The flash-open bit accepts any write in special mode. In normal mode only the first write that carries 0 in bit 4 takes effect, and a normal-mode write carrying 1 has no effect.
- R7: In normal mode the protect-lock bit takes the value of the first configuration write after reset and then holds. In special mode it can be set and cleared freely.
- R8: The wait-stop and dummy bits accept every configuration write in both modes.
- R9: The protect register (shadow protect and block protect bits) accepts writes only when prog_en_i is 0 and protect lock is 0.
- R10: Reserved bits ignore writes and read back fixed values: address 0 bits 7:2 read 0, configuration bit 3 reads 1, configuration bit 5 holds its shadow-loaded value, and protect bit 6 reads 1. Addresses 4 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; shadow word loads while low |
| special_i | input | 1 | 1 = special mode, 0 = normal mode |
| latch_en_i | input | 1 | Programming latch enable from controller; blocks divider writes |
| prog_en_i | input | 1 | Program/erase enable from controller; blocks protect writes |
| shadow_hi_i | input | 8 | Shadow word high byte |
| shadow_lo_i | input | 8 | Shadow word low byte |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W (3) | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| div_o | output | DIV_W (10) | Prescaler divider value |
| dbg_lock_dis_o | output | 1 | Debug lockout disable |
| shadow_dis_o | output | 1 | Shadow word disable |
| flash_open_o | output | 1 | Flash array open for program/erase |
| wait_stop_o | output | 1 | Stop module clock in wait mode |
| prot_lock_o | output | 1 | Protect lock |
| shadow_prot_o | output | 1 | Shadow word protection |
| blk_prot_o | output | BLK_W (6) | Per-block protection |

## Verification
Every visible field appears on an output port or on the read bus in the cycle after its write edge. A wrong value or a wrongly accepted write is therefore seen at the first read that follows. The hidden one-time flags show nothing until a second write in normal mode arrives. If such a flag was set too early, that second write, or a first write that should have been accepted, exposes it one cycle later. The bench therefore pairs a first write with a later write, and mixes blocked writes with accepted writes, before each read.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
   typedef enum logic [1:0] {
      POL_ANY      = 2'd0,
      POL_SPECIAL  = 2'd1,
      POL_ONCE     = 2'd2,
      POL_CLR_ONCE = 2'd3
   } wr_pol_e;

   localparam int unsigned NREG       = 4;
   localparam int unsigned A_DIV_HI   = 0;
   localparam int unsigned A_DIV_LO   = 1;
   localparam int unsigned A_CFG      = 2;
   localparam int unsigned A_PROT     = 3;
endpackage

// File: rtl/cfg_bank_decode.sv
module cfg_bank_decode #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NREG   = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   wr_strb
);
   for (genvar i = 0; i < NREG; i++) begin : g_strb
      assign wr_strb[i] = wr_en && (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/cfg_bank_field.sv
module cfg_bank_field
   import cfg_bank_pkg::*;
#(
   parameter int unsigned WIDTH  = 1,
   parameter wr_pol_e     POLICY = POL_ANY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             special,
   input  logic             wr,
   input  logic             gate,
   input  logic [WIDTH-1:0] rst_val,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("cfg_bank_field: WIDTH must be at least 1");
   end

   if (POLICY == POL_ANY) begin : g_any
      wire unused_special = special;
      always_ff @(posedge clk) begin
         if (!rst_n)          q <= rst_val;
         else if (wr && gate) q <= d;
      end
   end else if (POLICY == POL_SPECIAL) begin : g_special
      always_ff @(posedge clk) begin
         if (!rst_n)                     q <= rst_val;
         else if (wr && gate && special) q <= d;
      end
   end else if (POLICY == POL_ONCE) begin : g_once
      logic used;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q    <= rst_val;
            used <= 1'b0;
         end else if (wr && gate) begin
            if (special) begin
               q <= d;
            end else if (!used) begin
               q    <= d;
               used <= 1'b1;
            end
         end
      end
   end else begin : g_clr_once
      logic used;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q    <= rst_val;
            used <= 1'b0;
         end else if (wr && gate) begin
            if (special) begin
               q <= d;
            end else if (!used && (d == '0)) begin
               q    <= '0;
               used <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DIV_W  = 10,
   parameter int unsigned BLK_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_i,
   input  logic              latch_en_i,
   input  logic              prog_en_i,
   input  logic [7:0]        shadow_hi_i,
   input  logic [7:0]        shadow_lo_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic [DIV_W-1:0]  div_o,
   output logic              dbg_lock_dis_o,
   output logic              shadow_dis_o,
   output logic              flash_open_o,
   output logic              wait_stop_o,
   output logic              prot_lock_o,
   output logic              shadow_prot_o,
   output logic [BLK_W-1:0]  blk_prot_o
);
   localparam int unsigned DIV_HI_W = DIV_W - 8;
   localparam int unsigned HI_PAD   = 8 - DIV_HI_W;
   localparam int unsigned PROT_PAD = 7 - BLK_W;

   if (DIV_W < 9 || DIV_W > 10) begin : g_bad_div
      $error("cfg_bank: DIV_W must be 9 or 10 (upper bits come from shadow_hi[1:0])");
   end
   if (BLK_W < 1 || BLK_W > 6) begin : g_bad_blk
      $error("cfg_bank: BLK_W must be 1..6");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("cfg_bank: ADDR_W must cover four registers");
   end

   logic [NREG-1:0]     wr_strb;
   logic [DIV_HI_W-1:0] div_hi_q;
   logic [7:0]          div_lo_q;
   logic [1:0]          dbg_shd_q;
   logic                rsvd_q;
   logic                fo_q;
   logic                pl_q;
   logic [1:0]          ws_dm_q;
   logic [BLK_W:0]      prot_q;
   logic                div_gate;
   logic                prot_gate;

   wire unused_in = ^{shadow_hi_i[3:2], wdata_i[3]};

   cfg_bank_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
      .wr_en   (wr_en_i),
      .addr    (addr_i),
      .wr_strb (wr_strb)
   );

   assign div_gate  = !latch_en_i;
   assign prot_gate = !prog_en_i && !pl_q;

   cfg_bank_field #(.WIDTH(DIV_HI_W), .POLICY(POL_ONCE)) u_div_hi (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_DIV_HI]), .gate(div_gate),
      .rst_val(shadow_hi_i[DIV_HI_W-1:0]), .d(wdata_i[DIV_HI_W-1:0]), .q(div_hi_q)
   );

   cfg_bank_field #(.WIDTH(8), .POLICY(POL_ONCE)) u_div_lo (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_DIV_LO]), .gate(div_gate),
      .rst_val(shadow_lo_i), .d(wdata_i), .q(div_lo_q)
   );

   cfg_bank_field #(.WIDTH(2), .POLICY(POL_SPECIAL)) u_dbg_shd (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_CFG]), .gate(1'b1),
      .rst_val(shadow_hi_i[7:6]), .d(wdata_i[7:6]), .q(dbg_shd_q)
   );

   cfg_bank_field #(.WIDTH(1), .POLICY(POL_ANY)) u_rsvd (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_CFG]), .gate(1'b0),
      .rst_val(shadow_hi_i[5]), .d(wdata_i[5]), .q(rsvd_q)
   );

   cfg_bank_field #(.WIDTH(1), .POLICY(POL_CLR_ONCE)) u_fo (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_CFG]), .gate(1'b1),
      .rst_val(shadow_hi_i[4]), .d(wdata_i[4]), .q(fo_q)
   );

   cfg_bank_field #(.WIDTH(1), .POLICY(POL_ONCE)) u_pl (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_CFG]), .gate(1'b1),
      .rst_val(1'b0), .d(wdata_i[1]), .q(pl_q)
   );

   cfg_bank_field #(.WIDTH(2), .POLICY(POL_ANY)) u_ws_dm (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_CFG]), .gate(1'b1),
      .rst_val(2'b10), .d({wdata_i[2], wdata_i[0]}), .q(ws_dm_q)
   );

   cfg_bank_field #(.WIDTH(BLK_W + 1), .POLICY(POL_ANY)) u_prot (
      .clk(clk), .rst_n(rst_n), .special(special_i),
      .wr(wr_strb[A_PROT]), .gate(prot_gate),
      .rst_val({(BLK_W + 1){1'b1}}), .d({wdata_i[7], wdata_i[BLK_W-1:0]}), .q(prot_q)
   );

   always_comb begin
      rdata_o = 8'h00;
      unique case (addr_i)
         ADDR_W'(A_DIV_HI): rdata_o = {{HI_PAD{1'b0}}, div_hi_q};
         ADDR_W'(A_DIV_LO): rdata_o = div_lo_q;
         ADDR_W'(A_CFG):    rdata_o = {dbg_shd_q, rsvd_q, fo_q, 1'b1,
                                       ws_dm_q[1], pl_q, ws_dm_q[0]};
         ADDR_W'(A_PROT):   rdata_o = {prot_q[BLK_W], {PROT_PAD{1'b1}}, prot_q[BLK_W-1:0]};
         default:           rdata_o = 8'h00;
      endcase
   end

   assign div_o          = {div_hi_q, div_lo_q};
   assign dbg_lock_dis_o = dbg_shd_q[1];
   assign shadow_dis_o   = dbg_shd_q[0];
   assign flash_open_o   = fo_q;
   assign wait_stop_o    = ws_dm_q[1];
   assign prot_lock_o    = pl_q;
   assign shadow_prot_o  = prot_q[BLK_W];
   assign blk_prot_o     = prot_q[BLK_W-1:0];
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
   parameter int unsigned DIV_W = 10,
   parameter int unsigned BLK_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             special_i,
   input logic             latch_en_i,
   input logic             prog_en_i,
   input logic [DIV_W-1:0] div_o,
   input logic             dbg_lock_dis_o,
   input logic             shadow_dis_o,
   input logic             flash_open_o,
   input logic             prot_lock_o,
   input logic             shadow_prot_o,
   input logic [BLK_W-1:0] blk_prot_o
);
   AST_DIV_HELD_BY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en_i |=> $stable(div_o));  // R3

   AST_DBG_SHD_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !special_i |=> ($stable(dbg_lock_dis_o) && $stable(shadow_dis_o)));  // R5

   AST_FO_NO_RISE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      !special_i |=> !$rose(flash_open_o));  // R6

   AST_PL_NO_CLEAR_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_i && prot_lock_o) |=> prot_lock_o);  // R7

   AST_PROT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_en_i || prot_lock_o) |=> ($stable(blk_prot_o) && $stable(shadow_prot_o)));  // R9
endmodule

bind cfg_bank cfg_bank_chk #(.DIV_W(DIV_W), .BLK_W(BLK_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .special_i      (special_i),
   .latch_en_i     (latch_en_i),
   .prog_en_i      (prog_en_i),
   .div_o          (div_o),
   .dbg_lock_dis_o (dbg_lock_dis_o),
   .shadow_dis_o   (shadow_dis_o),
   .flash_open_o   (flash_open_o),
   .prot_lock_o    (prot_lock_o),
   .shadow_prot_o  (shadow_prot_o),
   .blk_prot_o     (blk_prot_o)
);

// File: tb/tb_cfg_bank.sv
`timescale 1ns/1ps
module tb_cfg_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_i = 1'b0;
   logic       latch_en_i = 1'b0;
   logic       prog_en_i = 1'b0;
   logic [7:0] shadow_hi_i = 8'h00;
   logic [7:0] shadow_lo_i = 8'h00;
   logic       wr_en_i = 1'b0;
   logic [2:0] addr_i = 3'd0;
   logic [7:0] wdata_i = 8'h00;
   logic [7:0] rdata_o;
   logic [9:0] div_o;
   logic       dbg_lock_dis_o, shadow_dis_o, flash_open_o, wait_stop_o;
   logic       prot_lock_o, shadow_prot_o;
   logic [5:0] blk_prot_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   cfg_bank dut (
      .clk(clk), .rst_n(rst_n), .special_i(special_i), .latch_en_i(latch_en_i),
      .prog_en_i(prog_en_i), .shadow_hi_i(shadow_hi_i), .shadow_lo_i(shadow_lo_i),
      .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .div_o(div_o), .dbg_lock_dis_o(dbg_lock_dis_o), .shadow_dis_o(shadow_dis_o),
      .flash_open_o(flash_open_o), .wait_stop_o(wait_stop_o), .prot_lock_o(prot_lock_o),
      .shadow_prot_o(shadow_prot_o), .blk_prot_o(blk_prot_o)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [7:0] hi, input logic [7:0] lo);
      @(negedge clk);
      rst_n = 1'b0; shadow_hi_i = hi; shadow_lo_i = lo;
      special_i = 1'b0; latch_en_i = 1'b0; prog_en_i = 1'b0; wr_en_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
      addr_i = a;
      #1;
      d = rdata_o;
   endtask

   task automatic t_reset_load;
      logic [7:0] r;
      do_reset(8'hB2, 8'h5A);
      check("R1 div_o after reset", 16'(div_o), 16'h25A);
      bus_rd(3'd0, r); check("R1 addr0 read", 16'(r), 16'h02);
      bus_rd(3'd1, r); check("R1 addr1 read", 16'(r), 16'h5A);
      bus_rd(3'd2, r); check("R2 cfg reset read", 16'(r), 16'hBC);
      bus_rd(3'd3, r); check("R2 prot reset read", 16'(r), 16'hFF);
      check("R2 outputs", 16'({dbg_lock_dis_o, shadow_dis_o, flash_open_o,
                               wait_stop_o, prot_lock_o, shadow_prot_o}), 16'b101101);
      bus_rd(3'd6, r); check("R10 unmapped read", 16'(r), 16'h00);
   endtask

   task automatic t_div_normal;
      logic [7:0] r;
      do_reset(8'h01, 8'h23);
      latch_en_i = 1'b1;
      bus_wr(3'd1, 8'h11);
      check("R3 blocked by latch", 16'(div_o), 16'h123);
      latch_en_i = 1'b0;
      bus_wr(3'd1, 8'h34);
      check("R3 first write after blocked one", 16'(div_o), 16'h134);
      bus_wr(3'd1, 8'h77);
      check("R4 second low write ignored", 16'(div_o), 16'h134);
      bus_wr(3'd0, 8'hFE);
      check("R4 high byte independent", 16'(div_o), 16'h234);
      bus_wr(3'd0, 8'h03);
      bus_rd(3'd0, r); check("R10 high reads 7:2 zero", 16'(r), 16'h02);
   endtask

   task automatic t_div_special;
      do_reset(8'h00, 8'h00);
      special_i = 1'b1;
      bus_wr(3'd1, 8'hAA);
      bus_wr(3'd1, 8'h55);
      check("R4 special repeated low", 16'(div_o), 16'h055);
      bus_wr(3'd0, 8'hFF);
      check("R4 special high write", 16'(div_o), 16'h355);
      latch_en_i = 1'b1;
      bus_wr(3'd1, 8'h00);
      check("R3 latch blocks special", 16'(div_o), 16'h355);
   endtask

   task automatic t_cfg_normal_a;
      logic [7:0] r;
      do_reset(8'hB2, 8'h00);
      bus_wr(3'd2, 8'h00);
      bus_rd(3'd2, r); check("R6 R8 normal write zero", 16'(r), 16'hA8);
      bus_wr(3'd2, 8'hFF);
      bus_rd(3'd2, r); check("R5 R7 R10 normal write ones", 16'(r), 16'hAD);
      check("R5 shadow_dis held", 16'(shadow_dis_o), 16'h0);
      check("R6 flash_open not set", 16'(flash_open_o), 16'h0);
      check("R7 prot_lock held", 16'(prot_lock_o), 16'h0);
   endtask

   task automatic t_cfg_normal_b;
      logic [7:0] r;
      do_reset(8'h10, 8'h00);
      bus_wr(3'd2, 8'h16);
      bus_rd(3'd2, r); check("R6 R7 write of 1 keeps open, lock set", 16'(r), 16'h1E);
      bus_wr(3'd2, 8'h04);
      bus_rd(3'd2, r); check("R6 later clear accepted, R7 held", 16'(r), 16'h0E);
      bus_wr(3'd2, 8'h14);
      bus_rd(3'd2, r); check("R6 no reopen in normal", 16'(r), 16'h0E);
   endtask

   task automatic t_cfg_special;
      logic [7:0] r;
      do_reset(8'h00, 8'h00);
      special_i = 1'b1;
      bus_wr(3'd2, 8'hD3);
      bus_rd(3'd2, r); check("R5 R6 R7 special set", 16'(r), 16'hDB);
      bus_wr(3'd2, 8'h00);
      bus_rd(3'd2, r); check("R5 R7 R8 special clear", 16'(r), 16'h08);
      bus_wr(3'd2, 8'h02);
      bus_wr(3'd2, 8'h00);
      check("R7 special re-clear", 16'(prot_lock_o), 16'h0);
   endtask

   task automatic t_prot;
      logic [7:0] r;
      do_reset(8'h00, 8'h00);
      bus_wr(3'd3, 8'h00);
      bus_rd(3'd3, r); check("R9 R10 prot write open", 16'(r), 16'h40);
      prog_en_i = 1'b1;
      bus_wr(3'd3, 8'hFF);
      bus_rd(3'd3, r); check("R9 blocked by prog_en", 16'(r), 16'h40);
      prog_en_i = 1'b0;
      bus_wr(3'd2, 8'h06);
      bus_wr(3'd3, 8'hBF);
      check("R9 blocked by lock", 16'({shadow_prot_o, blk_prot_o}), 16'h00);
      bus_wr(3'd5, 8'hFF);
      bus_rd(3'd3, r); check("R10 unmapped write no effect", 16'(r), 16'h40);
   endtask

   initial begin
      t_reset_load();
      t_div_normal();
      t_div_special();
      t_cfg_normal_a();
      t_cfg_normal_b();
      t_cfg_special();
      t_prot();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule